// File: doc/BRIEF.md
# Machine Trap CSR Controller

This block holds the machine-mode trap state of a 32-bit core that only ever runs at machine privilege. It keeps eight control and status registers: global status, interrupt enable, interrupt pending, trap vector, scratch, exception PC, trap cause and trap value. Software reaches them through a simple CSR access port with a combinational read path and a write that takes effect on the next rising clock edge.

The pipeline drives two strobes. A trap-entry strobe carries the faulting or interrupted PC, a cause code and an interrupt flag. A trap-return strobe restores the saved state. The block computes the handler target address from the vector register and the presented cause, and it presents the saved exception PC as the return target. It registers an interrupt request vector once per cycle to form the pending register. It does not arbitrate between interrupt sources and does not flush the pipeline. Every pin is a plain control or status signal. No part of the interface is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mtrap_csr_ctrl`

## Requirements
- R1: After reset the status register (0x300) reads 0x0000_1800. The vector register (0x305) reads {boot_addr[31:8], 6'b0, 2'b01}. Enable, pending, scratch, exception PC, cause and trap value all read zero.
- R2: The status register reads with bits 12:11 fixed at 11, the previous-enable flag in bit 7 and the global enable in bit 3. All other bits read zero. A CSR write changes only bit 3.
- R3: On trap entry, bit 7 of status takes the old bit 3 and bit 3 clears. The exception PC (0x341) captures the trap PC with bit 0 cleared. The cause register (0x342) captures {interrupt flag in bit 31, zeros in 30:5, code in 4:0}. All of these take effect on the next clock edge.
- R4: On trap return without trap entry, bit 3 of status takes bit 7 and bit 7 sets. `return_pc` always equals the exception PC register.
- R5: A write to the vector register stores bits 31:8 and bit 0. Bits 7:1 read zero.
- R6: `handler_pc` is the vector base (bits 31:8, low byte zero) when bit 0 of the vector register is 0, or when the interrupt flag is low. When bit 0 is 1 and the interrupt flag is high, it is base + 4 × code.
- R7: A write to the exception PC stores the data with bit 0 forced to zero. A write to the cause register stores bit 31 and bits 4:0, and bits 30:5 read zero.
- R8: The trap value register (0x343) reads zero and ignores writes. Any unmapped address reads zero. `csr_rdata` is zero while `csr_en` is low.
- R9: The enable register (0x304) stores only bits 31:16, 11, 7 and 3. The pending register (0x344) reads the `irq` value sampled at the previous clock edge, masked to those same bits, and ignores writes.
- R10: The scratch register (0x340) stores and returns all 32 bits.
- R11: When trap entry coincides with a CSR write to status, exception PC or cause, the trap update wins. A trap return also blocks a same-cycle status write. When entry and return coincide, entry wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_addr | input | 32 | Source of the vector register reset value |
| irq | input | 32 | Interrupt request lines, sampled every cycle |
| csr_en | input | 1 | CSR access this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| trap_enter | input | 1 | Trap-entry strobe |
| trap_return | input | 1 | Trap-return strobe |
| trap_is_irq | input | 1 | The trap being entered is an interrupt |
| trap_code | input | 5 | Cause code of the trap being entered |
| trap_pc | input | 32 | PC saved on trap entry |
| handler_pc | output | 32 | Handler target for the presented trap |
| return_pc | output | 32 | PC restored on trap return |

## Verification
The bench aims at the collisions. It drives trap entry with a same-cycle write to the exception PC, cause or status register, and it drives entry and return together. A design with the wrong priority would let software data overwrite the captured PC or enable bits. It sweeps vectored mode with exceptions and with the highest cause code. A design that offsets exceptions, or that truncates the offset, would send them to the wrong handler. It writes all-ones to every register to expose writable bits that should read zero, and it checks that pending lags `irq` by exactly one cycle.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int XLEN    = 32;
  localparam int CODE_W  = 5;
  localparam int ADDR_W  = 12;

  localparam logic [ADDR_W-1:0] A_STATUS  = 12'h300;
  localparam logic [ADDR_W-1:0] A_IENABLE = 12'h304;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 12'h305;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 12'h340;
  localparam logic [ADDR_W-1:0] A_EPC     = 12'h341;
  localparam logic [ADDR_W-1:0] A_CAUSE   = 12'h342;
  localparam logic [ADDR_W-1:0] A_TVAL    = 12'h343;
  localparam logic [ADDR_W-1:0] A_PENDING = 12'h344;

  localparam logic [XLEN-1:0] IRQ_LIVE_MASK = 32'hFFFF_0888;

  typedef struct packed {
    logic              enter;
    logic              ret;
    logic              is_irq;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   pc;
  } trap_evt_t;

  typedef struct packed {
    logic status;
    logic ienable;
    logic vector;
    logic scratch;
    logic epc;
    logic cause;
  } csr_wsel_t;
endpackage

// File: rtl/mtrap_status.sv
module mtrap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_gie,
  input  logic enter,
  input  logic ret,
  output logic gie,
  output logic prev_gie
);
  logic gie_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (enter) begin
      prev_q <= gie_q;
      gie_q  <= 1'b0;
    end else if (ret) begin
      gie_q  <= prev_q;
      prev_q <= 1'b1;
    end else if (wr_en) begin
      gie_q  <= wr_gie;
    end
  end

  assign gie      = gie_q;
  assign prev_gie = prev_q;

  p_entry_saves_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (!gie_q && prev_q == $past(gie_q)));

  p_return_restores_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !enter) |=> (prev_q && gie_q == $past(prev_q)));

  p_trap_blocks_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enter && wr_en) |=> !gie_q);
endmodule

// File: rtl/mtrap_vector.sv
module mtrap_vector #(
  parameter int XLEN       = 32,
  parameter int CODE_W     = 5,
  parameter int ALIGN_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [XLEN-1:ALIGN_BITS] boot_base,
  input  logic                  wr_en,
  input  logic [XLEN-1:ALIGN_BITS] wr_base,
  input  logic                  wr_mode,
  input  logic                  is_irq,
  input  logic [CODE_W-1:0]     code,
  output logic [XLEN-1:0]       vec_rd,
  output logic [XLEN-1:0]       handler_pc
);
  localparam int PAD_W = ALIGN_BITS - CODE_W - 2;

  logic [XLEN-1:ALIGN_BITS] base_q;
  logic                     mode_q;
  logic [ALIGN_BITS-1:0]    ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= boot_base;
      mode_q <= 1'b1;
    end else if (wr_en) begin
      base_q <= wr_base;
      mode_q <= wr_mode;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb ofs = (mode_q && is_irq) ? {{PAD_W{1'b0}}, code, 2'b00} : '0;
    end else begin : g_nopad
      always_comb ofs = (mode_q && is_irq) ? {code, 2'b00} : '0;
    end
  endgenerate

  assign handler_pc = {base_q, ofs};
  assign vec_rd     = {base_q, {(ALIGN_BITS-1){1'b0}}, mode_q};

  p_exception_hits_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_irq |-> (handler_pc[ALIGN_BITS-1:0] == '0));

  p_handler_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    handler_pc[1:0] == 2'b00);
endmodule

// File: rtl/mtrap_epc_cause.sv
module mtrap_epc_cause #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_epc,
  input  logic              wr_cause,
  input  logic [XLEN-1:1]   wr_pc_hi,
  input  logic              wr_irq_flag,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              enter,
  input  logic [XLEN-1:1]   trap_pc_hi,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   epc,
  output logic [XLEN-1:0]   cause
);
  logic [XLEN-1:1]   epc_q;
  logic              flag_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q  <= '0;
      flag_q <= 1'b0;
      code_q <= '0;
    end else if (enter) begin
      epc_q  <= trap_pc_hi;
      flag_q <= is_irq;
      code_q <= code;
    end else begin
      if (wr_epc) epc_q <= wr_pc_hi;
      if (wr_cause) begin
        flag_q <= wr_irq_flag;
        code_q <= wr_code;
      end
    end
  end

  assign epc   = {epc_q, 1'b0};
  assign cause = {flag_q, {(XLEN-1-CODE_W){1'b0}}, code_q};

  p_entry_captures_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (epc == {$past(trap_pc_hi), 1'b0}));

  p_entry_captures_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (cause[XLEN-1] == $past(is_irq) && cause[CODE_W-1:0] == $past(code)));
endmodule

// File: rtl/mtrap_csr_ctrl.sv
module mtrap_csr_ctrl
  import mtrap_pkg::*;
#(
  parameter int ALIGN_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   boot_addr,
  input  logic [XLEN-1:0]   irq,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              trap_enter,
  input  logic              trap_return,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_pc,
  output logic [XLEN-1:0]   handler_pc,
  output logic [XLEN-1:0]   return_pc
);
  trap_evt_t evt;
  csr_wsel_t wsel;
  logic      wr;

  logic            gie, prev_gie;
  logic [XLEN-1:0] vec_rd, epc, cause;
  logic [XLEN-1:0] ien_q, pend_q, scratch_q;
  logic [XLEN-1:0] status_rd, rd_mux;
  logic            unused_low_bits;

  assign unused_low_bits = ^{boot_addr[ALIGN_BITS-1:0], trap_pc[0]};

  assign evt = '{enter: trap_enter, ret: trap_return, is_irq: trap_is_irq,
                 code: trap_code, pc: trap_pc};

  assign wr = csr_en && csr_we;
  always_comb begin
    wsel         = '0;
    wsel.status  = wr && (csr_addr == A_STATUS);
    wsel.ienable = wr && (csr_addr == A_IENABLE);
    wsel.vector  = wr && (csr_addr == A_VECTOR);
    wsel.scratch = wr && (csr_addr == A_SCRATCH);
    wsel.epc     = wr && (csr_addr == A_EPC);
    wsel.cause   = wr && (csr_addr == A_CAUSE);
  end

  mtrap_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wsel.status),
    .wr_gie   (csr_wdata[3]),
    .enter    (evt.enter),
    .ret      (evt.ret),
    .gie      (gie),
    .prev_gie (prev_gie)
  );

  mtrap_vector #(
    .XLEN       (XLEN),
    .CODE_W     (CODE_W),
    .ALIGN_BITS (ALIGN_BITS)
  ) u_vector (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_base  (boot_addr[XLEN-1:ALIGN_BITS]),
    .wr_en      (wsel.vector),
    .wr_base    (csr_wdata[XLEN-1:ALIGN_BITS]),
    .wr_mode    (csr_wdata[0]),
    .is_irq     (evt.is_irq),
    .code       (evt.code),
    .vec_rd     (vec_rd),
    .handler_pc (handler_pc)
  );

  mtrap_epc_cause #(
    .XLEN   (XLEN),
    .CODE_W (CODE_W)
  ) u_epc_cause (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_epc      (wsel.epc),
    .wr_cause    (wsel.cause),
    .wr_pc_hi    (csr_wdata[XLEN-1:1]),
    .wr_irq_flag (csr_wdata[XLEN-1]),
    .wr_code     (csr_wdata[CODE_W-1:0]),
    .enter       (evt.enter),
    .trap_pc_hi  (evt.pc[XLEN-1:1]),
    .is_irq      (evt.is_irq),
    .code        (evt.code),
    .epc         (epc),
    .cause       (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      pend_q    <= '0;
      scratch_q <= '0;
    end else begin
      pend_q <= irq & IRQ_LIVE_MASK;
      if (wsel.ienable) ien_q     <= csr_wdata & IRQ_LIVE_MASK;
      if (wsel.scratch) scratch_q <= csr_wdata;
    end
  end

  always_comb begin
    status_rd     = '0;
    status_rd[12] = 1'b1;
    status_rd[11] = 1'b1;
    status_rd[7]  = prev_gie;
    status_rd[3]  = gie;
  end

  always_comb begin
    case (csr_addr)
      A_STATUS:  rd_mux = status_rd;
      A_IENABLE: rd_mux = ien_q;
      A_VECTOR:  rd_mux = vec_rd;
      A_SCRATCH: rd_mux = scratch_q;
      A_EPC:     rd_mux = epc;
      A_CAUSE:   rd_mux = cause;
      A_TVAL:    rd_mux = '0;
      A_PENDING: rd_mux = pend_q;
      default:   rd_mux = '0;
    endcase
  end

  assign csr_rdata = csr_en ? rd_mux : '0;
  assign return_pc = epc;

  p_pending_follows_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_addr == A_PENDING) |-> ((csr_rdata & ~IRQ_LIVE_MASK) == '0));

  p_idle_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_en |-> (csr_rdata == '0));
endmodule

// File: tb/mtrap_csr_ctrl_bench.sv
module mtrap_csr_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] boot_addr = 32'h8000_1234;
  logic [31:0] irq = '0;
  logic        csr_en = 1'b0, csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        trap_enter = 1'b0, trap_return = 1'b0, trap_is_irq = 1'b0;
  logic [4:0]  trap_code = '0;
  logic [31:0] trap_pc = '0;
  logic [31:0] handler_pc, return_pc;

  int checks = 0;
  int errors = 0;

  logic        m_gie, m_prev, m_mode;
  logic [31:0] m_base, m_epc, m_cause, m_ien, m_pend, m_scr;

  always #4 clk = ~clk;

  mtrap_csr_ctrl u_mtrap_csr_ctrl (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .irq(irq),
    .csr_en(csr_en), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .trap_enter(trap_enter), .trap_return(trap_return),
    .trap_is_irq(trap_is_irq), .trap_code(trap_code), .trap_pc(trap_pc),
    .handler_pc(handler_pc), .return_pc(return_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h300: return 32'h0000_1800 | (32'(m_prev) << 7) | (32'(m_gie) << 3);
      12'h304: return m_ien;
      12'h305: return {m_base[31:8], 7'b0, m_mode};
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h344: return m_pend;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h300: return "R2";
      12'h304, 12'h344: return "R9";
      12'h305: return "R5";
      12'h340: return "R10";
      12'h341, 12'h342: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] exp_handler(input logic isirq, input logic [4:0] c);
    if (m_mode && isirq) return {m_base[31:8], 8'h00} + {25'b0, c, 2'b00};
    return {m_base[31:8], 8'h00};
  endfunction

  // one cycle: drive at negedge, check combinational outputs, update model after edge
  task automatic step(input logic en, input logic we, input logic [11:0] a,
                      input logic [31:0] wd, input logic ent, input logic rt,
                      input logic isirq, input logic [4:0] c, input logic [31:0] pc,
                      input logic [31:0] iv);
    @(negedge clk);
    csr_en = en; csr_we = we; csr_addr = a; csr_wdata = wd;
    trap_enter = ent; trap_return = rt; trap_is_irq = isirq;
    trap_code = c; trap_pc = pc; irq = iv;
    #1;
    if (en && !we) chk(tag_of(a), csr_rdata, exp_read(a));
    if (!en) chk("R8", csr_rdata, 32'h0);
    chk("R6", handler_pc, exp_handler(isirq, c));
    chk("R4", return_pc, m_epc);
    @(posedge clk);
    if (ent) begin
      m_prev = m_gie; m_gie = 1'b0;
      m_epc = {pc[31:1], 1'b0};
      m_cause = {isirq, 26'b0, c};
    end else if (rt) begin
      m_gie = m_prev; m_prev = 1'b1;
    end
    if (en && we) begin
      case (a)
        12'h300: if (!ent && !rt) m_gie = wd[3];
        12'h304: m_ien = wd & 32'hFFFF_0888;
        12'h305: begin m_base = {wd[31:8], 8'h0}; m_mode = wd[0]; end
        12'h340: m_scr = wd;
        12'h341: if (!ent) m_epc = {wd[31:1], 1'b0};
        12'h342: if (!ent) m_cause = {wd[31], 26'b0, wd[4:0]};
        default: ;
      endcase
    end
    m_pend = iv & 32'hFFFF_0888;
  endtask

  task automatic rd(input logic [11:0] a);
    step(1'b1, 1'b0, a, 32'h0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, irq);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, irq);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] addrs [10];
    void'($urandom(32'h5EED));
    addrs = '{12'h300, 12'h304, 12'h305, 12'h340, 12'h341,
              12'h342, 12'h343, 12'h344, 12'h7A0, 12'h301};
    m_gie = 0; m_prev = 0; m_mode = 1; m_base = 32'h8000_1200;
    m_epc = 0; m_cause = 0; m_ien = 0; m_pend = 0; m_scr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: reset values seen on the read port before any other traffic
    @(negedge clk);
    csr_en = 1'b1; csr_we = 1'b0;
    csr_addr = 12'h300; #1 chk("R1", csr_rdata, 32'h0000_1800);
    csr_addr = 12'h305; #1 chk("R1", csr_rdata, 32'h8000_1201);
    csr_addr = 12'h341; #1 chk("R1", csr_rdata, 32'h0);
    csr_addr = 12'h342; #1 chk("R1", csr_rdata, 32'h0);
    csr_addr = 12'h340; #1 chk("R1", csr_rdata, 32'h0);
    csr_addr = 12'h304; #1 chk("R1", csr_rdata, 32'h0);

    // R2: only bit 3 of status is writable
    wr(12'h300, 32'hFFFF_FFFF); rd(12'h300);
    #1 chk("R2", exp_read(12'h300), 32'h0000_1808);
    // R3: exception entry with odd PC
    step(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b0, 1'b0, 5'd2, 32'h0000_1001, 32'h0);
    rd(12'h341); rd(12'h342); rd(12'h300);
    chk("R3", m_epc, 32'h0000_1000);
    // R5: all-ones to vector register
    wr(12'h305, 32'hFFFF_FFFF); rd(12'h305);
    // R6: vectored interrupt with highest code, and an exception in vectored mode
    step(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b0, 1'b1, 5'd31, 32'h40, 32'h0);
    step(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, 1'b0, 1'b0, 5'd31, 32'h44, 32'h0);
    // R4: return restores enable
    step(1'b0, 1'b0, 12'h0, 32'h0, 1'b0, 1'b1, 1'b0, 5'd0, 32'h0, 32'h0);
    rd(12'h300);
    // R11: entry beats a same-cycle write to exception PC, cause and status
    step(1'b1, 1'b1, 12'h341, 32'hAAAA_AAAA, 1'b1, 1'b0, 1'b1, 5'd7, 32'h2000, 32'h0);
    rd(12'h341);
    chk("R11", m_epc, 32'h0000_2000);
    step(1'b1, 1'b1, 12'h342, 32'h0000_001F, 1'b1, 1'b0, 1'b0, 5'd3, 32'h2004, 32'h0);
    rd(12'h342);
    step(1'b1, 1'b1, 12'h300, 32'h0000_0008, 1'b1, 1'b1, 1'b0, 5'd1, 32'h2008, 32'h0);
    rd(12'h300);
    // R8 and R9: trap value and pending ignore writes; pending lags irq one cycle
    wr(12'h343, 32'hFFFF_FFFF); rd(12'h343);
    step(1'b1, 1'b1, 12'h344, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 32'hFFFF_FFFF);
    rd(12'h344);
    wr(12'h304, 32'hFFFF_FFFF); rd(12'h304);
    // R10: scratch and R7 writes
    wr(12'h340, 32'hDEAD_BEEF); rd(12'h340);
    wr(12'h341, 32'h1234_5677); rd(12'h341);
    wr(12'h342, 32'hFFFF_FFFF); rd(12'h342);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [11:0] a;
      int unsigned op;
      a  = addrs[$urandom_range(0, 9)];
      op = $urandom_range(0, 9);
      step(op != 9, op < 4, a, $urandom(), op == 5 || op == 7, op == 6 || op == 7,
           1'($urandom()), 5'($urandom()), $urandom(), $urandom());
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule